// File: doc/BRIEF.md
# User-Level Network Port Checker

This block sits in a node's communication assist, between the network and the host. It offers each of several independent data networks a port that user code can use without calling the operating system. Each port is a set of message queues plus a status word. On the send side, each outgoing message is checked against a tag-indexed mapping table before it is queued. The block then wraps the message in an envelope that carries a user/system class bit, the tag and the destination context read from the table.

On the receive side, each arriving envelope is classified. The block looks at its class bit and at the mapping entry its tag selects. A message lands in that network's user input FIFO only when it is user-class and the entry is valid and owned by the current protection domain. Two kinds of message go to that network's system queue instead: system-class messages, and user-class messages that fail the check, which count as protection faults. A level interrupt stays asserted while any system queue holds a message.

Every network has its own output FIFO, user input FIFO and system queue. Backpressure on one network therefore never stalls another. The operating system loads the mapping table through a single write port.

Top module: `unp_port`

## Requirements
- R1: A received message with class bit 0 passes the check when its tag's mapping entry is valid and its domain equals `cur_dom`. Such a message enters the user input FIFO of its network together with the entry's context. It is visible at `usr_*` from the cycle after acceptance, and messages leave in arrival order.
- R2: A received message with class bit 1 enters its network's system queue with `sys_cause` = 0, whatever its mapping entry holds.
- R3: A received message with class bit 0 goes to its network's system queue with `sys_cause` = 1 (protection fault) in either of two cases: its mapping entry is invalid, or the entry's domain differs from `cur_dom`.
- R4: `irq` is high exactly when at least one system queue is non-empty. It rises the cycle after a message is queued there and falls only after a `sys_pop`.
- R5: `net_in_ready[n]` is low while the user input FIFO or the system queue of network n is full, and high otherwise. A full queue on one network leaves the other network's ready unaffected.
- R6: Status bit 2n is 1 when user input FIFO n is non-empty. Status bit 2n+1 is 1 when output FIFO n is full.
- R7: A send with `snd_sys` = 0 passes the same check as R1. It is queued, and the envelope {class 0, tag, entry context, data} appears at `net_out_*` of that network from the next cycle, in send order.
- R8: A send with `snd_sys` = 0 that fails the check is dropped. It puts nothing on the output, and `snd_fault[n]` is high for exactly the following cycle.
- R9: A send with `snd_sys` = 1 skips the check. It is emitted with class bit 1 and with the context field taken from the entry as stored.
- R10: After reset all queues are empty, `irq` is low, every ready is high, the status word is zero, and every mapping entry is invalid with domain and context 0.
- R11: `snd_ready[n]` is low while output FIFO n is full, and the FIFO holds its contents until the network takes a message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cur_dom | input | DOM_W | Protection domain of the running user context |
| map_we | input | 1 | Mapping-table write strobe |
| map_idx | input | TAG_W | Entry written |
| map_vld | input | 1 | Valid bit for the written entry |
| map_dom | input | DOM_W | Owning domain for the written entry |
| map_ctx | input | CTX_W | Destination context for the written entry |
| snd_valid | input | NUM_NET | Send request per network |
| snd_ready | output | NUM_NET | Output FIFO can take a message |
| snd_sys | input | NUM_NET | Send is system class |
| snd_tag | input | NUM_NET x TAG_W | Tag of each send |
| snd_data | input | NUM_NET x DATA_W | Payload of each send |
| snd_fault | output | NUM_NET | One-cycle pulse for a rejected send |
| net_out_valid | output | NUM_NET | Envelope available toward the network |
| net_out_ready | input | NUM_NET | Network takes the envelope |
| net_out_sys | output | NUM_NET | Envelope class bit |
| net_out_tag | output | NUM_NET x TAG_W | Envelope tag |
| net_out_ctx | output | NUM_NET x CTX_W | Translated destination context |
| net_out_data | output | NUM_NET x DATA_W | Envelope payload |
| net_in_valid | input | NUM_NET | Envelope arriving from the network |
| net_in_ready | output | NUM_NET | Port accepts the envelope |
| net_in_sys | input | NUM_NET | Arriving class bit |
| net_in_tag | input | NUM_NET x TAG_W | Arriving tag |
| net_in_data | input | NUM_NET x DATA_W | Arriving payload |
| usr_valid | output | NUM_NET | User input FIFO non-empty |
| usr_pop | input | NUM_NET | Remove the head of the user input FIFO |
| usr_ctx | output | NUM_NET x CTX_W | Context of the head message |
| usr_data | output | NUM_NET x DATA_W | Payload of the head message |
| sys_valid | output | NUM_NET | System queue non-empty |
| sys_pop | input | NUM_NET | Remove the head of the system queue |
| sys_cause | output | NUM_NET | 0 system message, 1 protection fault |
| sys_tag | output | NUM_NET x TAG_W | Tag of the system-queue head |
| sys_data | output | NUM_NET x DATA_W | Payload of the system-queue head |
| irq | output | 1 | Any system queue non-empty |
| status | output | 2 x NUM_NET | Per-network poll bits, see R6 |

## Verification
Every queue push happens on the clock edge that accepts a message. The resulting head, valid flag, `irq` and status bits are therefore due one cycle after that edge, and `snd_fault` is due in the same cycle. The ready outputs and status bits depend only on queue occupancy held in registers, so they never depend on the inputs of the same cycle. The bench model updates its queues at the rising edge, reading mapping entries as they stood before that edge's table write. It compares every output at the following falling edge, which is exactly the cycle in which each result becomes due.

// File: rtl/unp_pkg.sv
package unp_pkg;

   typedef enum logic {
      CAUSE_SYSMSG = 1'b0,
      CAUSE_FAULT  = 1'b1
   } sys_cause_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/unp_fifo.sv
module unp_fifo #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         push,
   input  logic [W-1:0] din,
   input  logic         pop,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   if (!unp_pkg::is_pow2(DEPTH)) begin : g_bad_depth
      $error("unp_fifo: DEPTH must be a power of two");
   end

   if (DEPTH == 1) begin : g_single
      logic         vld_q;
      logic [W-1:0] dat_q;

      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= 1'b0;
         end else if (push && !vld_q) begin
            vld_q <= 1'b1;
         end else if (pop && vld_q) begin
            vld_q <= 1'b0;
         end
      end

      always_ff @(posedge clk) begin
         if (push && !vld_q) dat_q <= din;
      end

      assign dout  = dat_q;
      assign empty = !vld_q;
      assign full  = vld_q;
   end else begin : g_ring
      logic [W-1:0]  mem [DEPTH];
      logic [AW-1:0] wp_q, rp_q;
      logic [AW:0]   cnt_q;
      logic          do_push, do_pop;

      assign full    = (cnt_q == (AW+1)'(DEPTH));
      assign empty   = (cnt_q == '0);
      assign do_push = push && !full;
      assign do_pop  = pop && !empty;

      always_ff @(posedge clk) begin
         if (rst) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
         end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
               2'b10:   cnt_q <= cnt_q + 1'b1;
               2'b01:   cnt_q <= cnt_q - 1'b1;
               default: cnt_q <= cnt_q;
            endcase
         end
      end

      always_ff @(posedge clk) begin
         if (do_push) mem[wp_q] <= din;
      end

      assign dout = mem[rp_q];
   end

endmodule

// File: rtl/unp_map_table.sv
module unp_map_table #(
   parameter int TAG_W = 3,
   parameter int DOM_W = 4,
   parameter int CTX_W = 4,
   parameter int NRD   = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       wr_en,
   input  logic [TAG_W-1:0]           wr_idx,
   input  logic                       wr_vld,
   input  logic [DOM_W-1:0]           wr_dom,
   input  logic [CTX_W-1:0]           wr_ctx,
   input  logic [NRD-1:0][TAG_W-1:0]  rd_idx,
   output logic [NRD-1:0]             rd_vld,
   output logic [NRD-1:0][DOM_W-1:0]  rd_dom,
   output logic [NRD-1:0][CTX_W-1:0]  rd_ctx
);
   localparam int ENT = 1 << TAG_W;

   logic             ent_vld [ENT];
   logic [DOM_W-1:0] ent_dom [ENT];
   logic [CTX_W-1:0] ent_ctx [ENT];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < ENT; i++) begin
            ent_vld[i] <= 1'b0;
            ent_dom[i] <= '0;
            ent_ctx[i] <= '0;
         end
      end else if (wr_en) begin
         ent_vld[wr_idx] <= wr_vld;
         ent_dom[wr_idx] <= wr_dom;
         ent_ctx[wr_idx] <= wr_ctx;
      end
   end

   for (genvar r = 0; r < NRD; r++) begin : g_rd
      assign rd_vld[r] = ent_vld[rd_idx[r]];
      assign rd_dom[r] = ent_dom[rd_idx[r]];
      assign rd_ctx[r] = ent_ctx[rd_idx[r]];
   end

endmodule

// File: rtl/unp_guard.sv
module unp_guard #(
   parameter int DOM_W = 4
) (
   input  logic             is_sys,
   input  logic             ent_vld,
   input  logic [DOM_W-1:0] ent_dom,
   input  logic [DOM_W-1:0] cur_dom,
   output logic             owner_ok
);
   always_comb begin
      owner_ok = !is_sys && ent_vld && (ent_dom == cur_dom);
   end
endmodule

// File: rtl/unp_port.sv
module unp_port #(
   parameter int NUM_NET  = 2,
   parameter int DATA_W   = 32,
   parameter int TAG_W    = 3,
   parameter int DOM_W    = 4,
   parameter int CTX_W    = 4,
   parameter int UQ_DEPTH = 4,
   parameter int SQ_DEPTH = 4,
   parameter int OQ_DEPTH = 4
) (
   input  logic                            clk,
   input  logic                            rst,
   input  logic [DOM_W-1:0]                cur_dom,
   input  logic                            map_we,
   input  logic [TAG_W-1:0]                map_idx,
   input  logic                            map_vld,
   input  logic [DOM_W-1:0]                map_dom,
   input  logic [CTX_W-1:0]                map_ctx,
   input  logic [NUM_NET-1:0]              snd_valid,
   output logic [NUM_NET-1:0]              snd_ready,
   input  logic [NUM_NET-1:0]              snd_sys,
   input  logic [NUM_NET-1:0][TAG_W-1:0]   snd_tag,
   input  logic [NUM_NET-1:0][DATA_W-1:0]  snd_data,
   output logic [NUM_NET-1:0]              snd_fault,
   output logic [NUM_NET-1:0]              net_out_valid,
   input  logic [NUM_NET-1:0]              net_out_ready,
   output logic [NUM_NET-1:0]              net_out_sys,
   output logic [NUM_NET-1:0][TAG_W-1:0]   net_out_tag,
   output logic [NUM_NET-1:0][CTX_W-1:0]   net_out_ctx,
   output logic [NUM_NET-1:0][DATA_W-1:0]  net_out_data,
   input  logic [NUM_NET-1:0]              net_in_valid,
   output logic [NUM_NET-1:0]              net_in_ready,
   input  logic [NUM_NET-1:0]              net_in_sys,
   input  logic [NUM_NET-1:0][TAG_W-1:0]   net_in_tag,
   input  logic [NUM_NET-1:0][DATA_W-1:0]  net_in_data,
   output logic [NUM_NET-1:0]              usr_valid,
   input  logic [NUM_NET-1:0]              usr_pop,
   output logic [NUM_NET-1:0][CTX_W-1:0]   usr_ctx,
   output logic [NUM_NET-1:0][DATA_W-1:0]  usr_data,
   output logic [NUM_NET-1:0]              sys_valid,
   input  logic [NUM_NET-1:0]              sys_pop,
   output logic [NUM_NET-1:0]              sys_cause,
   output logic [NUM_NET-1:0][TAG_W-1:0]   sys_tag,
   output logic [NUM_NET-1:0][DATA_W-1:0]  sys_data,
   output logic                            irq,
   output logic [2*NUM_NET-1:0]            status
);
   import unp_pkg::*;

   localparam int NRD = 2 * NUM_NET;
   localparam int U_W = CTX_W + DATA_W;
   localparam int S_W = 1 + TAG_W + DATA_W;
   localparam int O_W = 1 + TAG_W + CTX_W + DATA_W;

   if (NUM_NET < 1 || TAG_W < 1 || DOM_W < 1 || CTX_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("unp_port: every width and the network count must be at least 1");
   end
   if (!is_pow2(UQ_DEPTH) || !is_pow2(SQ_DEPTH) || !is_pow2(OQ_DEPTH)) begin : g_bad_depth
      $error("unp_port: queue depths must be powers of two");
   end

   logic [NRD-1:0][TAG_W-1:0] rd_idx;
   logic [NRD-1:0]            rd_vld;
   logic [NRD-1:0][DOM_W-1:0] rd_dom;
   logic [NRD-1:0][CTX_W-1:0] rd_ctx;

   logic [NUM_NET-1:0] rx_user_ok, tx_user_ok;
   logic [NUM_NET-1:0] u_empty, u_full, s_empty, s_full, o_empty, o_full;
   logic [NUM_NET-1:0] fault_q;

   unp_map_table #(
      .TAG_W (TAG_W),
      .DOM_W (DOM_W),
      .CTX_W (CTX_W),
      .NRD   (NRD)
   ) u_map (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (map_we),
      .wr_idx (map_idx),
      .wr_vld (map_vld),
      .wr_dom (map_dom),
      .wr_ctx (map_ctx),
      .rd_idx (rd_idx),
      .rd_vld (rd_vld),
      .rd_dom (rd_dom),
      .rd_ctx (rd_ctx)
   );

   for (genvar n = 0; n < NUM_NET; n++) begin : g_net
      logic           rx_acc, tx_acc, tx_ok;
      logic [U_W-1:0] u_din, u_dout;
      logic [S_W-1:0] s_din, s_dout;
      logic [O_W-1:0] o_din, o_dout;
      sys_cause_e     rx_cause;

      assign rd_idx[n]           = net_in_tag[n];
      assign rd_idx[NUM_NET + n] = snd_tag[n];

      // receive path
      unp_guard #(.DOM_W(DOM_W)) u_rx_guard (
         .is_sys   (net_in_sys[n]),
         .ent_vld  (rd_vld[n]),
         .ent_dom  (rd_dom[n]),
         .cur_dom  (cur_dom),
         .owner_ok (rx_user_ok[n])
      );

      assign net_in_ready[n] = !u_full[n] && !s_full[n];
      assign rx_acc          = net_in_valid[n] && net_in_ready[n];
      assign rx_cause        = net_in_sys[n] ? CAUSE_SYSMSG : CAUSE_FAULT;
      assign u_din           = {rd_ctx[n], net_in_data[n]};
      assign s_din           = {rx_cause, net_in_tag[n], net_in_data[n]};

      unp_fifo #(.W(U_W), .DEPTH(UQ_DEPTH)) u_uq (
         .clk   (clk),
         .rst   (rst),
         .push  (rx_acc && rx_user_ok[n]),
         .din   (u_din),
         .pop   (usr_pop[n]),
         .dout  (u_dout),
         .empty (u_empty[n]),
         .full  (u_full[n])
      );

      unp_fifo #(.W(S_W), .DEPTH(SQ_DEPTH)) u_sq (
         .clk   (clk),
         .rst   (rst),
         .push  (rx_acc && !rx_user_ok[n]),
         .din   (s_din),
         .pop   (sys_pop[n]),
         .dout  (s_dout),
         .empty (s_empty[n]),
         .full  (s_full[n])
      );

      assign usr_valid[n] = !u_empty[n];
      assign {usr_ctx[n], usr_data[n]} = u_dout;
      assign sys_valid[n] = !s_empty[n];
      assign {sys_cause[n], sys_tag[n], sys_data[n]} = s_dout;

      // send path
      unp_guard #(.DOM_W(DOM_W)) u_tx_guard (
         .is_sys   (snd_sys[n]),
         .ent_vld  (rd_vld[NUM_NET + n]),
         .ent_dom  (rd_dom[NUM_NET + n]),
         .cur_dom  (cur_dom),
         .owner_ok (tx_user_ok[n])
      );

      assign snd_ready[n] = !o_full[n];
      assign tx_acc       = snd_valid[n] && snd_ready[n];
      assign tx_ok        = snd_sys[n] || tx_user_ok[n];
      assign o_din        = {snd_sys[n], snd_tag[n], rd_ctx[NUM_NET + n], snd_data[n]};

      unp_fifo #(.W(O_W), .DEPTH(OQ_DEPTH)) u_oq (
         .clk   (clk),
         .rst   (rst),
         .push  (tx_acc && tx_ok),
         .din   (o_din),
         .pop   (net_out_ready[n]),
         .dout  (o_dout),
         .empty (o_empty[n]),
         .full  (o_full[n])
      );

      always_ff @(posedge clk) begin
         if (rst) fault_q[n] <= 1'b0;
         else     fault_q[n] <= tx_acc && !tx_ok;
      end

      assign net_out_valid[n] = !o_empty[n];
      assign {net_out_sys[n], net_out_tag[n], net_out_ctx[n], net_out_data[n]} = o_dout;

      assign status[2*n]     = !u_empty[n];
      assign status[2*n + 1] = o_full[n];
   end

   assign snd_fault = fault_q;
   assign irq       = !(&s_empty);

endmodule

// File: rtl/unp_port_chk.sv
module unp_port_chk #(
   parameter int NUM_NET = 2
) (
   input logic               clk,
   input logic               rst,
   input logic [NUM_NET-1:0] net_in_valid,
   input logic [NUM_NET-1:0] net_in_ready,
   input logic [NUM_NET-1:0] net_in_sys,
   input logic [NUM_NET-1:0] rx_user_ok,
   input logic [NUM_NET-1:0] usr_valid,
   input logic [NUM_NET-1:0] sys_pop,
   input logic               irq,
   input logic [NUM_NET-1:0] snd_valid,
   input logic [NUM_NET-1:0] snd_sys,
   input logic [NUM_NET-1:0] snd_ready,
   input logic [NUM_NET-1:0] snd_fault,
   input logic [NUM_NET-1:0] net_out_valid,
   input logic [NUM_NET-1:0] net_out_ready
);
   for (genvar n = 0; n < NUM_NET; n++) begin : g_chk
      a_r1_user_lands: assert property (@(posedge clk) disable iff (rst)
         (net_in_valid[n] && net_in_ready[n] && !net_in_sys[n] && rx_user_ok[n]) |=> usr_valid[n]);

      a_r2_sys_raises_irq: assert property (@(posedge clk) disable iff (rst)
         (net_in_valid[n] && net_in_ready[n] && net_in_sys[n]) |=> irq);

      a_r3_fault_raises_irq: assert property (@(posedge clk) disable iff (rst)
         (net_in_valid[n] && net_in_ready[n] && !net_in_sys[n] && !rx_user_ok[n]) |=> irq);

      a_r8_fault_from_user_send: assert property (@(posedge clk) disable iff (rst)
         snd_fault[n] |-> $past(snd_valid[n] && !snd_sys[n]));

      a_r11_full_holds: assert property (@(posedge clk) disable iff (rst)
         (!snd_ready[n] && !(net_out_valid[n] && net_out_ready[n])) |=> !snd_ready[n]);
   end

   a_r4_irq_falls_on_pop: assert property (@(posedge clk) disable iff (rst)
      $fell(irq) |-> $past(|sys_pop));

endmodule

bind unp_port unp_port_chk #(.NUM_NET(NUM_NET)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .net_in_valid  (net_in_valid),
   .net_in_ready  (net_in_ready),
   .net_in_sys    (net_in_sys),
   .rx_user_ok    (rx_user_ok),
   .usr_valid     (usr_valid),
   .sys_pop       (sys_pop),
   .irq           (irq),
   .snd_valid     (snd_valid),
   .snd_sys       (snd_sys),
   .snd_ready     (snd_ready),
   .snd_fault     (snd_fault),
   .net_out_valid (net_out_valid),
   .net_out_ready (net_out_ready)
);

// File: tb/unp_port_bench.sv
module unp_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NN = 2;
   localparam int DW = 32;
   localparam int TW = 3;
   localparam int MW = 4;
   localparam int CW = 4;
   localparam int QD = 4;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [MW-1:0] cur_dom = '0;
   logic map_we = 1'b0;
   logic [TW-1:0] map_idx = '0;
   logic map_vld = 1'b0;
   logic [MW-1:0] map_dom = '0;
   logic [CW-1:0] map_ctx = '0;
   logic [NN-1:0] snd_valid = '0, snd_sys = '0, net_out_ready = '0;
   logic [NN-1:0][TW-1:0] snd_tag = '0, net_in_tag = '0;
   logic [NN-1:0][DW-1:0] snd_data = '0, net_in_data = '0;
   logic [NN-1:0] net_in_valid = '0, net_in_sys = '0, usr_pop = '0, sys_pop = '0;
   logic [NN-1:0] snd_ready, snd_fault, net_out_valid, net_out_sys, net_in_ready;
   logic [NN-1:0] usr_valid, sys_valid, sys_cause;
   logic [NN-1:0][TW-1:0] net_out_tag, sys_tag;
   logic [NN-1:0][CW-1:0] net_out_ctx, usr_ctx;
   logic [NN-1:0][DW-1:0] net_out_data, usr_data, sys_data;
   logic irq;
   logic [2*NN-1:0] status;

   unp_port u_unp_port (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_err = 0, cyc = 0;
   bit done = 0;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference model
   logic [63:0] uq [NN][$];
   logic [63:0] sq [NN][$];
   logic [63:0] oq [NN][$];
   logic m_vld [8];
   logic [MW-1:0] m_dom [8];
   logic [CW-1:0] m_ctx [8];
   logic [NN-1:0] m_fault;

   always @(posedge clk) begin
      int pu, ps, po, t;
      if (rst) begin
         for (int n = 0; n < NN; n++) begin
            uq[n].delete(); sq[n].delete(); oq[n].delete();
         end
         for (int i = 0; i < 8; i++) begin
            m_vld[i] = 0; m_dom[i] = 0; m_ctx[i] = 0;
         end
         m_fault = '0;
      end else begin
         for (int n = 0; n < NN; n++) begin
            pu = uq[n].size(); ps = sq[n].size(); po = oq[n].size();
            if (usr_pop[n] && pu > 0) void'(uq[n].pop_front());
            if (sys_pop[n] && ps > 0) void'(sq[n].pop_front());
            if (net_out_ready[n] && po > 0) void'(oq[n].pop_front());
            if (net_in_valid[n] && pu < QD && ps < QD) begin
               t = int'(net_in_tag[n]);
               if (!net_in_sys[n] && m_vld[t] && m_dom[t] == cur_dom)
                  uq[n].push_back({m_ctx[t], net_in_data[n]});
               else
                  sq[n].push_back({!net_in_sys[n], net_in_tag[n], net_in_data[n]});
            end
            m_fault[n] = 1'b0;
            if (snd_valid[n] && po < QD) begin
               t = int'(snd_tag[n]);
               if (snd_sys[n] || (m_vld[t] && m_dom[t] == cur_dom))
                  oq[n].push_back({snd_sys[n], snd_tag[n], m_ctx[t], snd_data[n]});
               else
                  m_fault[n] = 1'b1;
            end
         end
         if (map_we) begin
            m_vld[map_idx] = map_vld; m_dom[map_idx] = map_dom; m_ctx[map_idx] = map_ctx;
         end
      end
   end

   // per-cycle comparison at the falling edge
   always @(negedge clk) begin
      logic any_s;
      if (!rst && !done) begin
         any_s = 0;
         for (int n = 0; n < NN; n++) begin
            any_s = any_s | (sq[n].size() > 0);
            chk("R11 snd_ready", 64'(snd_ready[n]), 64'(oq[n].size() < QD));
            chk("R5 net_in_ready", 64'(net_in_ready[n]), 64'(uq[n].size() < QD && sq[n].size() < QD));
            chk("R7 net_out_valid", 64'(net_out_valid[n]), 64'(oq[n].size() > 0));
            if (oq[n].size() > 0)
               chk("R7 R9 envelope", 64'({net_out_sys[n], net_out_tag[n], net_out_ctx[n], net_out_data[n]}), oq[n][0]);
            chk("R1 usr_valid", 64'(usr_valid[n]), 64'(uq[n].size() > 0));
            if (uq[n].size() > 0)
               chk("R1 user head", 64'({usr_ctx[n], usr_data[n]}), uq[n][0]);
            chk("R2 R3 sys_valid", 64'(sys_valid[n]), 64'(sq[n].size() > 0));
            if (sq[n].size() > 0)
               chk("R2 R3 system head", 64'({sys_cause[n], sys_tag[n], sys_data[n]}), sq[n][0]);
            chk("R8 snd_fault", 64'(snd_fault[n]), 64'(m_fault[n]));
            chk("R6 status user bit", 64'(status[2*n]), 64'(uq[n].size() > 0));
            chk("R6 status full bit", 64'(status[2*n+1]), 64'(oq[n].size() == QD));
         end
         chk("R4 irq", 64'(irq), 64'(any_s));
      end
   end

   task automatic map_wr(int idx, bit v, int d, int c);
      @(negedge clk);
      map_we = 1; map_idx = TW'(idx); map_vld = v; map_dom = MW'(d); map_ctx = CW'(c);
      @(negedge clk);
      map_we = 0;
   endtask

   task automatic rx(int n, bit s, int tag, int data);
      net_in_valid[n] = 1; net_in_sys[n] = s; net_in_tag[n] = TW'(tag); net_in_data[n] = DW'(data);
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      #1;
      // R10 reset state
      chk("R10 irq", 64'(irq), 0);
      chk("R10 net_in_ready", 64'(net_in_ready), 64'(2'b11));
      chk("R10 snd_ready", 64'(snd_ready), 64'(2'b11));
      chk("R10 status", 64'(status), 0);
      chk("R10 usr_valid", 64'(usr_valid), 0);

      // R10/R3: table empty after reset -> user message faults
      @(negedge clk); rx(0, 0, 5, 32'hAAAA_0001);
      @(negedge clk); net_in_valid = '0;
      chk("R3 unmapped tag to system queue", 64'({sys_valid[0], sys_cause[0]}), 64'(2'b11));
      @(negedge clk); sys_pop = 2'b01;
      @(negedge clk); sys_pop = '0;

      cur_dom = 1;
      map_wr(0, 1, 1, 5);
      map_wr(1, 1, 2, 6);
      map_wr(2, 0, 1, 9);
      map_wr(3, 1, 1, 7);

      // mixed receive on both networks
      @(negedge clk); rx(0, 0, 0, 32'h100); rx(1, 0, 3, 32'h200);
      @(negedge clk); rx(0, 1, 2, 32'h101); rx(1, 0, 1, 32'h201);
      @(negedge clk); rx(0, 0, 2, 32'h102); rx(1, 0, 0, 32'h202);
      @(negedge clk); net_in_valid = '0;
      chk("R1 user head ctx", 64'(usr_ctx[1]), 64'(7));
      chk("R4 irq after system message", 64'(irq), 1);
      usr_pop = 2'b11; sys_pop = 2'b11;
      repeat (5) @(negedge clk);
      usr_pop = '0; sys_pop = '0;

      // R5: fill net0 user FIFO while net1 keeps flowing
      for (int k = 0; k < 7; k++) begin
         rx(0, 0, 0, 32'h300 + k); rx(1, 0, 3, 32'h400 + k);
         usr_pop[1] = (k > 0);
         @(negedge clk);
      end
      net_in_valid = '0; usr_pop = '0;
      chk("R5 net0 blocked, net1 open", 64'(net_in_ready), 64'(2'b10));
      usr_pop = 2'b11;
      repeat (5) @(negedge clk);
      usr_pop = '0;

      // send side with output held
      net_out_ready = '0;
      snd_valid[0] = 1; snd_sys[0] = 1; snd_tag[0] = 2; snd_data[0] = 32'h500;
      @(negedge clk); snd_valid = '0;
      chk("R9 system send emitted", 64'({net_out_valid[0], net_out_sys[0], net_out_tag[0]}), 64'({2'b11, 3'd2}));
      snd_valid[0] = 1; snd_sys[0] = 0; snd_tag[0] = 2; snd_data[0] = 32'h501;
      @(negedge clk); snd_valid = '0;
      chk("R8 invalid tag fault pulse", 64'(snd_fault[0]), 1);
      snd_valid[0] = 1; snd_tag[0] = 1; snd_data[0] = 32'h502;
      @(negedge clk); snd_valid = '0;
      chk("R8 foreign tag fault pulse", 64'(snd_fault[0]), 1);
      for (int k = 0; k < 5; k++) begin
         snd_valid[0] = 1; snd_tag[0] = 0; snd_data[0] = 32'h600 + k;
         @(negedge clk);
      end
      snd_valid = '0;
      chk("R11 output full", 64'(snd_ready[0]), 0);
      chk("R6 full bit", 64'(status[1]), 1);
      net_out_ready = 2'b11;
      repeat (6) @(negedge clk);

      // random traffic
      for (int k = 0; k < 3000; k++) begin
         net_in_valid = NN'($urandom);
         net_in_sys = NN'($urandom_range(0, 3) == 0 ? $urandom : 0);
         snd_valid = NN'($urandom);
         snd_sys = NN'($urandom_range(0, 3) == 0 ? $urandom : 0);
         for (int n = 0; n < NN; n++) begin
            net_in_tag[n] = TW'($urandom); net_in_data[n] = $urandom;
            snd_tag[n] = TW'($urandom); snd_data[n] = $urandom;
         end
         usr_pop = NN'($urandom); sys_pop = NN'($urandom); net_out_ready = NN'($urandom);
         map_we = ($urandom_range(0, 15) == 0);
         map_idx = TW'($urandom); map_vld = $urandom_range(0, 3) != 0;
         map_dom = MW'($urandom_range(1, 2)); map_ctx = CW'($urandom);
         if ($urandom_range(0, 63) == 0) cur_dom = MW'($urandom_range(1, 2));
         @(negedge clk);
      end
      net_in_valid = '0; snd_valid = '0; map_we = 0;
      usr_pop = '1; sys_pop = '1; net_out_ready = '1;
      repeat (8) @(negedge clk);
      chk("R4 irq low after drain", 64'(irq), 0);
      finish_run();
   end

endmodule